// File: doc/BRIEF.md
# SDRAM Bank State Protocol Monitor

This block sits beside an SDRAM controller and listens to the command pins of a four-bank synchronous DRAM. It keeps its own copy of each bank's state: idle, open with a row, draining a burst that will close itself, or recovering from a precharge. From that copy it can tell when the controller issues a command the memory would not accept. It does not model stored data or analogue timing. Every timing window it checks is a whole number of clocks, set by a parameter.

When a command breaks a rule, the monitor sets one bit in an error vector and keeps it set until reset. The command that broke the rule is dropped from the monitor's bank model. The command code and bank of the first violation since reset are held in a capture register. The per-bank open flags and open row addresses are also brought out, so a bench or a debug bus can follow how the controller moves through the banks.

Top module: `sdram_bank_monitor`

## Requirements
- R1: A command is sampled on a rising clock edge only when cke is high and cs_n is low. It is decoded from {ras_n,cas_n,we_n}: 3'b011 activate, 3'b101 read, 3'b100 write, 3'b010 precharge, 3'b001 auto-refresh, 3'b000 mode-register load, 3'b110 burst stop, 3'b111 no-operation.
- R2: An activate to an idle bank opens that bank. The next cycle, bank_open[bank] reads 1 and the bank's ADDR_W-bit field of open_row (bank b at bits b*ADDR_W upward) holds the addr value of the activate.
- R3: A read or write to a bank that is not open, or whose row is draining toward an auto-close, sets err_flags bit 0.
- R4: A precharge with addr bit AP_BIT low closes only the bank on ba. With that bit high it closes every open bank. A closed bank's bank_open bit is 0 the next cycle.
- R5: A read or write with addr bit AP_BIT high keeps its bank reported open for BURST_LEN cycles after the command. The bank then closes and starts precharge recovery, so a new activate to it is accepted BURST_LEN+T_RP cycles after the command and no earlier.
- R6: A mode-register load while any bank is open (including draining) sets err_flags bit 1. With all banks closed it raises nothing.
- R7: After an accepted auto-refresh, any command other than no-operation in the following T_RFC-1 cycles sets err_flags bit 2. A command T_RFC cycles after the refresh is judged normally.
- R8: An activate, or a single-bank precharge, to a bank that is draining or is within T_RP-1 cycles after its precharge sets err_flags bit 3. An activate exactly T_RP cycles after an explicit precharge is accepted.
- R9: An activate to a bank that is already open sets err_flags bit 4.
- R10: A command that raises an error changes no bank state and no open row. Each command raises at most one bit, and the refresh lockout takes precedence over every other rule.
- R11: Reset clears all bank state, err_flags and first_valid. Error bits stay set until reset. The first error sets first_valid and stores first_cmd = {ras_n,cas_n,we_n} and first_bank = ba of that command, and later errors leave them unchanged.
- R12: With cs_n high or cke low, the address, bank and command pins have no effect on any output.

Default parameters: NUM_BANKS 4, ADDR_W 12, AP_BIT 10, BURST_LEN 4, T_RP 3, T_RFC 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the SDRAM interface |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock enable seen at the memory |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_W | Bank select |
| addr | input | ADDR_W | Address lines; bit AP_BIT selects all-bank or auto-close |
| bank_open | output | NUM_BANKS | One bit per bank, 1 while a row is open or draining |
| open_row | output | NUM_BANKS*ADDR_W | Row held by each bank, valid while its bank_open bit is 1 |
| err_flags | output | 5 | Sticky violation bits (see R3, R6 to R9) |
| first_valid | output | 1 | A violation has been captured |
| first_cmd | output | 3 | {ras_n,cas_n,we_n} of the first violating command |
| first_bank | output | BANK_W | Bank select of the first violating command |

## Verification
Two updates can land on the same clock edge. One bank's auto-close ends its drain and moves into recovery. At that same edge, an activate to a different bank is accepted. The bench provokes this by issuing that activate exactly BURST_LEN cycles after an auto-closing read. It judges the result from the open mask: the draining bank must drop out and the new bank must appear in one step. It also checks that a repeat activate to the draining bank is refused up to the last recovery cycle and accepted on the cycle after. The refresh window gets the same paired treatment: a burst stop on the last locked cycle must be flagged, and an activate on the next cycle must open its bank.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

    // Command code is {ras_n, cas_n, we_n} while the chip is selected.
    typedef enum logic [2:0] {
        CMD_MRS = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_ACT = 3'b011,
        CMD_WR  = 3'b100,
        CMD_RD  = 3'b101,
        CMD_BST = 3'b110,
        CMD_NOP = 3'b111
    } sdram_cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE  = 2'd0,
        BK_OPEN  = 2'd1,
        BK_DRAIN = 2'd2,
        BK_PRECH = 2'd3
    } bank_state_e;

    localparam int unsigned ERR_W         = 5;
    localparam int unsigned ERR_NO_ROW    = 0;
    localparam int unsigned ERR_MODE_BUSY = 1;
    localparam int unsigned ERR_RFC_LOCK  = 2;
    localparam int unsigned ERR_PRE_LOCK  = 3;
    localparam int unsigned ERR_ACT_OPEN  = 4;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic       cke,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    output sdram_cmd_e cmd
);

    // Deselected or clock-disabled cycles collapse to a no-operation.
    always_comb begin
        if (cke && !cs_n) begin
            cmd = sdram_cmd_e'({ras_n, cas_n, we_n});
        end else begin
            cmd = CMD_NOP;
        end
    end

endmodule

// File: rtl/sdram_refresh_guard.sv
module sdram_refresh_guard #(
    parameter int unsigned T_RFC = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam bit          LOCK_ON = (T_RFC > 1);
    localparam int unsigned LOAD    = (T_RFC > 2) ? T_RFC - 2 : 0;
    localparam int unsigned CW      = $clog2(LOAD + 2);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } guard_t;

    guard_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (start && LOCK_ON) begin
            g_d.busy = 1'b1;
            g_d.cnt  = CW'(LOAD);
        end else if (g_q.busy) begin
            if (g_q.cnt == '0) begin
                g_d.busy = 1'b0;
            end else begin
                g_d.cnt = g_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign busy = g_q.busy;

    p_refresh_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && LOCK_ON) |=> busy);

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
    import sdram_mon_pkg::*;
#(
    parameter int unsigned ROW_W     = 12,
    parameter int unsigned BURST_LEN = 4,
    parameter int unsigned T_RP      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_act,
    input  logic              do_rw,
    input  logic              auto_close,
    input  logic              do_pre,
    input  logic [ROW_W-1:0]  row_in,
    output bank_state_e       state_o,
    output logic [ROW_W-1:0]  row_o
);

    localparam bit          PRE_ON     = (T_RP > 1);
    localparam int unsigned PRE_LOAD   = (T_RP > 2) ? T_RP - 2 : 0;
    localparam int unsigned DRAIN_LOAD = (BURST_LEN > 1) ? BURST_LEN - 1 : 0;
    localparam int unsigned MAX_LOAD   = (PRE_LOAD > DRAIN_LOAD) ? PRE_LOAD : DRAIN_LOAD;
    localparam int unsigned CW         = $clog2(MAX_LOAD + 2);

    typedef struct packed {
        bank_state_e      st;
        logic [CW-1:0]    cnt;
        logic [ROW_W-1:0] row;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        case (b_q.st)
            BK_IDLE: begin
                if (do_act) begin
                    b_d.st  = BK_OPEN;
                    b_d.row = row_in;
                end
            end
            BK_OPEN: begin
                if (do_pre) begin
                    b_d.st  = PRE_ON ? BK_PRECH : BK_IDLE;
                    b_d.cnt = CW'(PRE_LOAD);
                end else if (do_rw && auto_close) begin
                    b_d.st  = BK_DRAIN;
                    b_d.cnt = CW'(DRAIN_LOAD);
                end
            end
            BK_DRAIN: begin
                if (b_q.cnt == '0) begin
                    b_d.st  = PRE_ON ? BK_PRECH : BK_IDLE;
                    b_d.cnt = CW'(PRE_LOAD);
                end else begin
                    b_d.cnt = b_q.cnt - 1'b1;
                end
            end
            default: begin
                if (b_q.cnt == '0) begin
                    b_d.st = BK_IDLE;
                end else begin
                    b_d.cnt = b_q.cnt - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign state_o = b_q.st;
    assign row_o   = b_q.row;

    p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (do_act && b_q.st == BK_IDLE) |=> (state_o == BK_OPEN && row_o == $past(row_in)));

    p_pre_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (do_pre && b_q.st == BK_OPEN) |=> (state_o != BK_OPEN && state_o != BK_DRAIN));

    p_drain_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (b_q.st == BK_DRAIN && b_q.cnt == '0) |=> (state_o == BK_PRECH || state_o == BK_IDLE));

endmodule

// File: rtl/sdram_bank_monitor.sv
module sdram_bank_monitor
    import sdram_mon_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned AP_BIT    = 10,
    parameter int unsigned BURST_LEN = 4,
    parameter int unsigned T_RP      = 3,
    parameter int unsigned T_RFC     = 7,
    parameter int unsigned BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cke,
    input  logic                          cs_n,
    input  logic                          ras_n,
    input  logic                          cas_n,
    input  logic                          we_n,
    input  logic [BANK_W-1:0]             ba,
    input  logic [ADDR_W-1:0]             addr,
    output logic [NUM_BANKS-1:0]          bank_open,
    output logic [NUM_BANKS*ADDR_W-1:0]   open_row,
    output logic [ERR_W-1:0]              err_flags,
    output logic                          first_valid,
    output logic [2:0]                    first_cmd,
    output logic [BANK_W-1:0]             first_bank
);

    sdram_cmd_e            cmd;
    logic                  rfc_busy;
    logic                  rfc_start;
    logic                  ap_bit;
    logic                  any_open;
    logic                  cmd_ok;
    logic [ERR_W-1:0]      err_now;
    bank_state_e           tgt_st;
    bank_state_e           bank_st  [NUM_BANKS];
    logic [ADDR_W-1:0]     bank_row [NUM_BANKS];
    logic [NUM_BANKS-1:0]  do_act;
    logic [NUM_BANKS-1:0]  do_rw;
    logic [NUM_BANKS-1:0]  do_pre;
    logic [NUM_BANKS-1:0]  open_vec;

    typedef struct packed {
        logic [ERR_W-1:0]  err;
        logic              fv;
        logic [2:0]        fcmd;
        logic [BANK_W-1:0] fbank;
    } mon_t;

    mon_t m_d, m_q;

    sdram_cmd_decode u_decode (
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    sdram_refresh_guard #(.T_RFC(T_RFC)) u_rfc (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rfc_start),
        .busy  (rfc_busy)
    );

    assign ap_bit   = addr[AP_BIT];
    assign tgt_st   = bank_st[ba];
    assign any_open = |open_vec;

    // Rule check: one cause per command, refresh lockout first.
    always_comb begin
        err_now = '0;
        if (cmd != CMD_NOP) begin
            if (rfc_busy) begin
                err_now[ERR_RFC_LOCK] = 1'b1;
            end else begin
                case (cmd)
                    CMD_ACT: begin
                        if (tgt_st == BK_OPEN) begin
                            err_now[ERR_ACT_OPEN] = 1'b1;
                        end else if (tgt_st != BK_IDLE) begin
                            err_now[ERR_PRE_LOCK] = 1'b1;
                        end
                    end
                    CMD_RD, CMD_WR: begin
                        if (tgt_st != BK_OPEN) begin
                            err_now[ERR_NO_ROW] = 1'b1;
                        end
                    end
                    CMD_PRE: begin
                        if (!ap_bit && (tgt_st == BK_DRAIN || tgt_st == BK_PRECH)) begin
                            err_now[ERR_PRE_LOCK] = 1'b1;
                        end
                    end
                    CMD_MRS: begin
                        if (any_open) begin
                            err_now[ERR_MODE_BUSY] = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign cmd_ok    = (cmd != CMD_NOP) && (err_now == '0);
    assign rfc_start = cmd_ok && (cmd == CMD_REF);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit       = (ba == BANK_W'(b));
        assign do_act[b] = cmd_ok && (cmd == CMD_ACT) && hit;
        assign do_rw[b]  = cmd_ok && (cmd == CMD_RD || cmd == CMD_WR) && hit;
        assign do_pre[b] = cmd_ok && (cmd == CMD_PRE) && (ap_bit || hit);

        sdram_bank_fsm #(
            .ROW_W     (ADDR_W),
            .BURST_LEN (BURST_LEN),
            .T_RP      (T_RP)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .do_act     (do_act[b]),
            .do_rw      (do_rw[b]),
            .auto_close (ap_bit),
            .do_pre     (do_pre[b]),
            .row_in     (addr),
            .state_o    (bank_st[b]),
            .row_o      (bank_row[b])
        );

        assign open_vec[b]                  = (bank_st[b] == BK_OPEN) || (bank_st[b] == BK_DRAIN);
        assign open_row[b*ADDR_W +: ADDR_W] = bank_row[b];
    end

    always_comb begin
        m_d     = m_q;
        m_d.err = m_q.err | err_now;
        if ((err_now != '0) && !m_q.fv) begin
            m_d.fv    = 1'b1;
            m_d.fcmd  = cmd;
            m_d.fbank = ba;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign bank_open   = open_vec;
    assign err_flags   = m_q.err;
    assign first_valid = m_q.fv;
    assign first_cmd   = m_q.fcmd;
    assign first_bank  = m_q.fbank;

    p_single_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(err_now));

    p_first_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        first_valid |=> (first_valid && $stable(first_cmd) && $stable(first_bank)));

    p_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || !cke) |=> ($stable(err_flags) && $stable(open_row)));

    p_mode_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cs_n && {ras_n, cas_n, we_n} == 3'b000 && (|bank_open) && !rfc_busy)
        |=> err_flags[ERR_MODE_BUSY]);

    p_no_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cs_n && {ras_n, cas_n} == 2'b10 && !rfc_busy && tgt_st != BK_OPEN)
        |=> err_flags[ERR_NO_ROW]);

endmodule

// File: tb/test_sdram_bank_monitor.sv
`timescale 1ns/1ps
module test_sdram_bank_monitor;

    localparam int NB = 4;
    localparam int AW = 12;
    localparam int BW = 2;

    localparam logic [2:0] C_MRS = 3'b000;
    localparam logic [2:0] C_REF = 3'b001;
    localparam logic [2:0] C_PRE = 3'b010;
    localparam logic [2:0] C_ACT = 3'b011;
    localparam logic [2:0] C_WR  = 3'b100;
    localparam logic [2:0] C_RD  = 3'b101;
    localparam logic [2:0] C_BST = 3'b110;
    localparam logic [2:0] C_NOP = 3'b111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke = 1'b1;
    logic cs_n = 1'b1;
    logic ras_n = 1'b1;
    logic cas_n = 1'b1;
    logic we_n = 1'b1;
    logic [BW-1:0] ba = '0;
    logic [AW-1:0] addr = '0;

    logic [NB-1:0]    bank_open;
    logic [NB*AW-1:0] open_row;
    logic [4:0]       err_flags;
    logic             first_valid;
    logic [2:0]       first_cmd;
    logic [BW-1:0]    first_bank;

    always #2.5 clk = ~clk;

    sdram_bank_monitor i_sdram_bank_monitor (
        .clk         (clk),
        .rst_n       (rst_n),
        .cke         (cke),
        .cs_n        (cs_n),
        .ras_n       (ras_n),
        .cas_n       (cas_n),
        .we_n        (we_n),
        .ba          (ba),
        .addr        (addr),
        .bank_open   (bank_open),
        .open_row    (open_row),
        .err_flags   (err_flags),
        .first_valid (first_valid),
        .first_cmd   (first_cmd),
        .first_bank  (first_bank)
    );

    typedef struct {
        logic [NB-1:0]    open;
        logic [NB*AW-1:0] row;
        logic [4:0]       err;
        logic             fv;
        logic [2:0]       fcmd;
        logic [BW-1:0]    fbank;
        string            tag;
    } exp_t;

    exp_t sb[$];

    logic [NB-1:0]    e_open;
    logic [NB*AW-1:0] e_row;
    logic [4:0]       e_err;
    logic             e_fv;
    logic [2:0]       e_fcmd;
    logic [BW-1:0]    e_fbank;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    task automatic compare(exp_t e);
        bit bad = 1'b0;
        vectors++;
        if (bank_open !== e.open) begin
            $display("FAIL %s: bank_open got %b expected %b", e.tag, bank_open, e.open);
            bad = 1'b1;
        end
        for (int b = 0; b < NB; b++) begin
            if (e.open[b] && open_row[b*AW +: AW] !== e.row[b*AW +: AW]) begin
                $display("FAIL %s: open_row bank %0d got %h expected %h",
                         e.tag, b, open_row[b*AW +: AW], e.row[b*AW +: AW]);
                bad = 1'b1;
            end
        end
        if (err_flags !== e.err) begin
            $display("FAIL %s: err_flags got %b expected %b", e.tag, err_flags, e.err);
            bad = 1'b1;
        end
        if (first_valid !== e.fv) begin
            $display("FAIL %s: first_valid got %b expected %b", e.tag, first_valid, e.fv);
            bad = 1'b1;
        end
        if (e.fv && (first_cmd !== e.fcmd || first_bank !== e.fbank)) begin
            $display("FAIL %s: capture got cmd %b bank %0d expected cmd %b bank %0d",
                     e.tag, first_cmd, first_bank, e.fcmd, e.fbank);
            bad = 1'b1;
        end
        if (bad) miscompares++;
    endtask

    task automatic set_row(int b, logic [AW-1:0] v);
        e_row[b*AW +: AW] = v;
    endtask

    task automatic set_err(logic [4:0] err, logic [2:0] fc, logic [BW-1:0] fb);
        e_err = err;
        if (!e_fv) begin
            e_fv    = 1'b1;
            e_fcmd  = fc;
            e_fbank = fb;
        end
    endtask

    // Driver: apply one cycle of pins and push what the outputs must show after the edge.
    task automatic drive(logic c_cs, logic c_cke, logic [2:0] c, logic [BW-1:0] b,
                         logic [AW-1:0] a, string tag);
        exp_t e;
        @(negedge clk);
        cs_n = c_cs;
        cke  = c_cke;
        {ras_n, cas_n, we_n} = c;
        ba   = b;
        addr = a;
        e.open  = e_open;
        e.row   = e_row;
        e.err   = e_err;
        e.fv    = e_fv;
        e.fcmd  = e_fcmd;
        e.fbank = e_fbank;
        e.tag   = tag;
        sb.push_back(e);
    endtask

    task automatic issue(logic [2:0] c, logic [BW-1:0] b, logic [AW-1:0] a, string tag);
        drive(1'b0, 1'b1, c, b, a, tag);
    endtask

    task automatic idle(string tag);
        drive(1'b0, 1'b1, C_NOP, '0, '0, tag);
    endtask

    task automatic do_reset();
        exp_t e;
        @(negedge clk);
        rst_n = 1'b0;
        cs_n  = 1'b1;
        cke   = 1'b1;
        {ras_n, cas_n, we_n} = C_NOP;
        ba    = '0;
        addr  = '0;
        e_open = '0; e_row = '0; e_err = '0; e_fv = 1'b0; e_fcmd = '0; e_fbank = '0;
        repeat (2) @(negedge clk);
        e.open = '0; e.row = '0; e.err = '0; e.fv = 1'b0; e.fcmd = '0; e.fbank = '0;
        e.tag  = "R11 reset state";
        compare(e);
        rst_n = 1'b1;
    endtask

    // Monitor: one expected item per driven cycle, read just after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) compare(sb.pop_front());
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R11 watchdog: got no completion, expected finish within limit");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // Legal traffic: open, access, ignored pins, precharge single and all.
        do_reset();
        e_open = 4'b0001; set_row(0, 12'h123);
        issue(C_ACT, 0, 12'h123, "R2 activate bank0");
        e_open = 4'b0101; set_row(2, 12'hABC);
        issue(C_ACT, 2, 12'hABC, "R2 activate bank2");
        drive(1'b1, 1'b1, C_RD, 1, 12'h000, "R12 read pins with cs_n high");
        drive(1'b0, 1'b0, C_ACT, 1, 12'h055, "R12 activate pins with cke low");
        drive(1'b1, 1'b1, C_MRS, 0, 12'h000, "R12 mode pins with cs_n high");
        issue(C_RD, 0, 12'h004, "R1 read decoded on open bank");
        issue(C_WR, 2, 12'h008, "R1 write decoded on open bank");
        e_open = 4'b0100;
        issue(C_PRE, 0, 12'h000, "R4 single-bank precharge");
        idle("R8 recovery cycle 1");
        idle("R8 recovery cycle 2");
        e_open = 4'b0101; set_row(0, 12'h005);
        issue(C_ACT, 0, 12'h005, "R8 activate exactly T_RP after precharge");
        e_open = 4'b0000;
        issue(C_PRE, 1, 12'h400, "R4 all-bank precharge");
        idle("R4 banks stay closed");

        // Missing row, sticky capture, mode load checks.
        do_reset();
        set_err(5'b00001, C_RD, 1);
        issue(C_RD, 1, 12'h000, "R3 read to idle bank");
        issue(C_WR, 3, 12'h000, "R11 second error keeps first capture");
        issue(C_MRS, 0, 12'h030, "R6 mode load with all banks idle");
        e_open = 4'b0010; set_row(1, 12'h0AA);
        issue(C_ACT, 1, 12'h0AA, "R2 activate after errors");
        set_err(5'b00011, C_MRS, 0);
        issue(C_MRS, 0, 12'h030, "R6 mode load with bank open");
        idle("R11 error bits stay set");

        // Refresh lockout boundaries.
        do_reset();
        issue(C_REF, 0, 12'h000, "R7 auto-refresh accepted");
        idle("R7 lock cycle 1");
        idle("R7 lock cycle 2");
        set_err(5'b00100, C_ACT, 0);
        issue(C_ACT, 0, 12'h010, "R10 activate in refresh lock is dropped");
        idle("R7 lock cycle 4");
        idle("R7 lock cycle 5");
        issue(C_BST, 0, 12'h000, "R7 burst stop on last locked cycle");
        e_open = 4'b0001; set_row(0, 12'h011);
        issue(C_ACT, 0, 12'h011, "R7 activate T_RFC after refresh");

        // Auto-close drain, coincident activate to another bank, recovery lock.
        do_reset();
        e_open = 4'b0010; set_row(1, 12'h0F0);
        issue(C_ACT, 1, 12'h0F0, "R2 activate bank1");
        issue(C_RD, 1, 12'h400, "R5 read with auto-close, bank still open");
        idle("R5 draining cycle 2");
        set_err(5'b00001, C_RD, 1);
        issue(C_RD, 1, 12'h000, "R3 read to draining bank");
        idle("R5 draining cycle 4");
        e_open = 4'b0001; set_row(0, 12'h321);
        issue(C_ACT, 0, 12'h321, "R5 drain ends while bank0 opens");
        idle("R5 bank1 recovering");
        set_err(5'b01001, C_RD, 1);
        issue(C_ACT, 1, 12'h0F1, "R8 activate on last recovery cycle");
        e_open = 4'b0011; set_row(1, 12'h0F1);
        issue(C_ACT, 1, 12'h0F1, "R5 activate BURST_LEN+T_RP after auto-close");

        // Double activate and explicit precharge lock.
        do_reset();
        e_open = 4'b1000; set_row(3, 12'h7FF);
        issue(C_ACT, 3, 12'h7FF, "R2 activate bank3");
        set_err(5'b10000, C_ACT, 3);
        issue(C_ACT, 3, 12'h001, "R9 activate to open bank keeps row");
        e_open = 4'b0000;
        issue(C_PRE, 3, 12'h000, "R4 precharge bank3");
        idle("R8 recovery cycle 1");
        set_err(5'b11000, C_ACT, 3);
        issue(C_ACT, 3, 12'h002, "R8 activate inside recovery");
        e_open = 4'b1000; set_row(3, 12'h003);
        issue(C_ACT, 3, 12'h003, "R8 activate after recovery");

        @(negedge clk);
        cs_n = 1'b1;
        {ras_n, cas_n, we_n} = C_NOP;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule